// File: doc/BRIEF.md
# No-Turnaround Synchronous SRAM Core

A behavioural single-port synchronous SRAM that accepts a new read or write on every rising clock edge, so that read, write and read commands may follow each other on consecutive cycles without idle cycles. Each word is 36 bits wide, in four 9-bit byte lanes. The depth is set by a parameter. The address, chip enable and write controls are sampled on the rising edge. Output enable and sleep act on the data outputs at once, without waiting for a clock edge.

The read latency is chosen with a mode input. In flow-through mode the addressed word appears on the outputs during the cycle after the command edge. In pipelined mode it passes through an output register and appears one cycle later. Write data is taken from the data input at the same offset after its command that read data would use. Because of this, the shared bus carries data for consecutive commands in order and never needs a turnaround cycle.

A read may target a word whose write is still in flight. In that case it returns the in-flight bytes merged over the stored word. The mode input is expected to change only while no command is outstanding.

Top module: `nbt_sram_core`

## Requirements
- R1: While reset is high, and in the cycle after it, `dq_drv` is low.
- R2: With `pipe_mode` low, a read command sampled at edge n drives the addressed word on `dq_out` with `dq_drv` high from edge n until edge n+1.
- R3: With `pipe_mode` high, a read command sampled at edge n drives the addressed word from edge n+1 until edge n+2.
- R4: The data of a write command sampled at edge n is taken from `dq_in` at edge n+1 with `pipe_mode` low, and at edge n+2 with `pipe_mode` high. `dq_drv` stays low in the cycle that carries write data.
- R5: With `gw` low and `bwe` high, only the byte lanes whose `byte_en` bit i is set are written, lane i being bits [9i+8:9i]. With `byte_en` all zero, the word is left unchanged.
- R6: With `gw` high, all four lanes are written, whatever the values of `bwe` and `byte_en`.
- R7: Any mix of reads, writes and idles may be issued on consecutive edges, and every read returns the word as left by all earlier writes.
- R8: In pipelined mode, a read issued on the edge right after a write to the same address returns that write's lanes merged over the old word.
- R9: While `sleep` is high, commands sampled at an edge have no effect, `dq_drv` is low at once, and stored words are kept.
- R10: While `oe` is low, `dq_drv` is low at once, even with a read due.
- R11: An edge with `ce` low is an idle: it writes nothing and drives nothing in the slot it would have used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the command pipeline |
| pipe_mode | input | 1 | 0 = flow-through reads, 1 = pipelined reads |
| ce | input | 1 | Chip enable; low makes the edge an idle |
| gw | input | 1 | Global write: write all lanes |
| bwe | input | 1 | Byte-write enable, qualified by `byte_en` |
| byte_en | input | 4 | Per-lane write strobes |
| addr | input | ADDR_W | Word address |
| dq_in | input | 36 | Write data, sampled at the delayed slot |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous sleep: ignore commands, float outputs |
| dq_out | output | 36 | Read data, zero while not driven |
| dq_drv | output | 1 | High while the block drives the bus; low means high impedance |

## Verification
If the command pipeline is off by one stage, `dq_drv` rises one cycle early or late. The idle-slot check sees this in the first read after reset. If a write's data is taken in the wrong slot, or forwarding is missing, a wrong word shows up on the next read of that address. With the small random address range, that read usually comes within a few cycles, and for R8 on the very next edge. A wrong lane mask shows as a corrupted lane on the next read of that word. A missing async gate shows `dq_drv` high within the same half cycle in which `oe` falls or `sleep` rises.

// File: rtl/nbt_pkg.sv
package nbt_pkg;

    localparam int NBT_LANES  = 4;
    localparam int NBT_LANE_W = 9;
    localparam int NBT_WORD_W = NBT_LANES * NBT_LANE_W;

    typedef logic [NBT_WORD_W-1:0] word_t;
    typedef logic [NBT_LANES-1:0]  lanes_t;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        op_e    op;
        lanes_t lanes;
    } cmd_t;

    // Widen a per-lane strobe to a per-bit mask.
    function automatic word_t lane_expand(lanes_t l);
        word_t m;
        for (int i = 0; i < NBT_LANES; i++) begin
            m[i*NBT_LANE_W +: NBT_LANE_W] = {NBT_LANE_W{l[i]}};
        end
        return m;
    endfunction

    // Overlay the strobed lanes of upd onto base.
    function automatic word_t lane_merge(word_t base, word_t upd, lanes_t l);
        word_t m;
        m = lane_expand(l);
        return (base & ~m) | (upd & m);
    endfunction

    // Turn the sampled control pins into one command.
    function automatic cmd_t decode(logic ce, logic sleep, logic gw,
                                    logic bwe, lanes_t strobes);
        cmd_t c;
        c.lanes = '0;
        if (!ce || sleep) begin
            c.op = OP_NONE;
        end else if (gw) begin
            c.op    = OP_WRITE;
            c.lanes = '1;
        end else if (bwe) begin
            c.op    = OP_WRITE;
            c.lanes = strobes;
        end else begin
            c.op = OP_READ;
        end
        return c;
    endfunction

endpackage

// File: rtl/nbt_cmd_stage.sv
module nbt_cmd_stage
    import nbt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              sleep,
    input  logic              gw,
    input  logic              bwe,
    input  lanes_t            strobes,
    input  logic [ADDR_W-1:0] addr,
    output cmd_t              s1_cmd,
    output logic [ADDR_W-1:0] s1_addr,
    output cmd_t              s2_cmd,
    output logic [ADDR_W-1:0] s2_addr
);

    cmd_t next_cmd;

    always_comb begin
        next_cmd = decode(ce, sleep, gw, bwe, strobes);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_cmd  <= '{op: OP_NONE, lanes: '0};
            s2_cmd  <= '{op: OP_NONE, lanes: '0};
            s1_addr <= '0;
            s2_addr <= '0;
        end else begin
            s1_cmd  <= next_cmd;
            s1_addr <= addr;
            s2_cmd  <= s1_cmd;
            s2_addr <= s1_addr;
        end
    end

endmodule

// File: rtl/nbt_array.sv
module nbt_array
    import nbt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  lanes_t            wr_lanes,
    input  word_t             wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output word_t             rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < NBT_LANES; g++) begin : g_lane
        logic [NBT_LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_lanes[g]) begin
                lane_mem[wr_addr] <= wr_data[g*NBT_LANE_W +: NBT_LANE_W];
            end
        end

        assign rd_data[g*NBT_LANE_W +: NBT_LANE_W] = lane_mem[rd_addr];
    end

endmodule

// File: rtl/nbt_read_path.sv
module nbt_read_path
    import nbt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pipe_mode,
    input  logic              oe,
    input  logic              sleep,
    input  cmd_t              s1_cmd,
    input  logic [ADDR_W-1:0] s1_addr,
    input  cmd_t              s2_cmd,
    input  logic [ADDR_W-1:0] s2_addr,
    input  word_t             arr_data,
    input  word_t             dq_in,
    output word_t             dq_out,
    output logic              dq_drv
);

    word_t out_q;
    logic  out_vld_q;
    logic  fwd_hit;
    word_t fwd_word;
    logic  rd_now;
    logic  sel_vld;
    word_t sel_word;

    // In pipelined mode the write in stage 2 commits on the same edge that
    // loads the output register, so its lanes are taken from the bus here.
    always_comb begin
        fwd_hit  = pipe_mode && (s2_cmd.op == OP_WRITE) && (s2_addr == s1_addr);
        fwd_word = fwd_hit ? lane_merge(arr_data, dq_in, s2_cmd.lanes) : arr_data;
        rd_now   = (s1_cmd.op == OP_READ);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld_q <= 1'b0;
            out_q     <= '0;
        end else begin
            out_vld_q <= rd_now;
            if (rd_now) begin
                out_q <= fwd_word;
            end
        end
    end

    always_comb begin
        sel_vld  = pipe_mode ? out_vld_q : rd_now;
        sel_word = pipe_mode ? out_q     : arr_data;
        dq_drv   = sel_vld && oe && !sleep;
        dq_out   = dq_drv ? sel_word : '0;
    end

endmodule

// File: rtl/nbt_sram_core.sv
module nbt_sram_core
    import nbt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pipe_mode,
    input  logic                  ce,
    input  logic                  gw,
    input  logic                  bwe,
    input  logic [NBT_LANES-1:0]  byte_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [NBT_WORD_W-1:0] dq_in,
    input  logic                  oe,
    input  logic                  sleep,
    output logic [NBT_WORD_W-1:0] dq_out,
    output logic                  dq_drv
);

    cmd_t              s1_cmd, s2_cmd;
    logic [ADDR_W-1:0] s1_addr, s2_addr;
    cmd_t              commit_cmd;
    logic [ADDR_W-1:0] commit_addr;
    word_t             arr_data;

    nbt_cmd_stage #(.ADDR_W(ADDR_W)) u_cmd (
        .clk     (clk),
        .rst     (rst),
        .ce      (ce),
        .sleep   (sleep),
        .gw      (gw),
        .bwe     (bwe),
        .strobes (byte_en),
        .addr    (addr),
        .s1_cmd  (s1_cmd),
        .s1_addr (s1_addr),
        .s2_cmd  (s2_cmd),
        .s2_addr (s2_addr)
    );

    // A write commits when its data slot arrives on the bus.
    always_comb begin
        commit_cmd  = pipe_mode ? s2_cmd  : s1_cmd;
        commit_addr = pipe_mode ? s2_addr : s1_addr;
    end

    nbt_array #(.ADDR_W(ADDR_W)) u_array (
        .clk      (clk),
        .wr_en    (commit_cmd.op == OP_WRITE),
        .wr_addr  (commit_addr),
        .wr_lanes (commit_cmd.lanes),
        .wr_data  (dq_in),
        .rd_addr  (s1_addr),
        .rd_data  (arr_data)
    );

    nbt_read_path #(.ADDR_W(ADDR_W)) u_read (
        .clk       (clk),
        .rst       (rst),
        .pipe_mode (pipe_mode),
        .oe        (oe),
        .sleep     (sleep),
        .s1_cmd    (s1_cmd),
        .s1_addr   (s1_addr),
        .s2_cmd    (s2_cmd),
        .s2_addr   (s2_addr),
        .arr_data  (arr_data),
        .dq_in     (dq_in),
        .dq_out    (dq_out),
        .dq_drv    (dq_drv)
    );

endmodule

// File: rtl/nbt_sram_checker.sv
module nbt_sram_checker (
    input logic clk,
    input logic rst,
    input logic pipe_mode,
    input logic ce,
    input logic gw,
    input logic bwe,
    input logic oe,
    input logic sleep,
    input logic dq_drv
);

    logic rd_cmd;
    assign rd_cmd = ce && !sleep && !gw && !bwe;

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !dq_drv); // R1

    AST_FT_READ_SLOT: assert property (@(posedge clk) disable iff (rst)
        (rd_cmd && !pipe_mode) |=> (dq_drv || !oe || sleep)); // R2

    AST_PIPE_READ_SLOT: assert property (@(posedge clk) disable iff (rst)
        (rd_cmd && pipe_mode) |=> ##1 (dq_drv || !oe || sleep)); // R3

    AST_OE_FLOATS: assert property (@(posedge clk) disable iff (rst)
        !oe |-> !dq_drv); // R10

    AST_SLEEP_FLOATS: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !dq_drv); // R9

    AST_FT_IGNORED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!pipe_mode && (!ce || sleep)) |=> !dq_drv); // R11

endmodule

bind nbt_sram_core nbt_sram_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .pipe_mode (pipe_mode),
    .ce        (ce),
    .gw        (gw),
    .bwe       (bwe),
    .oe        (oe),
    .sleep     (sleep),
    .dq_drv    (dq_drv)
);

// File: tb/nbt_sram_core_test.sv
`timescale 1ns/1ps
module nbt_sram_core_test;

    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;
    localparam int WW    = 36;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pipe_mode = 1'b0;
    logic          ce = 1'b0, gw = 1'b0, bwe = 1'b0, oe = 1'b1, sleep = 1'b0;
    logic [3:0]    byte_en = '0;
    logic [AW-1:0] addr = '0;
    logic [WW-1:0] dq_in = '0;
    logic [WW-1:0] dq_out;
    logic          dq_drv;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [WW-1:0] ref_mem [DEPTH];
    int            s_kind [3];   // 0 none, 1 read due, 2 write data due
    logic [WW-1:0] s_data [3];
    string         s_tag  [3];

    localparam int OP_IDLE = 0, OP_RD = 1, OP_GW = 2, OP_BW = 3, OP_GWBW = 4;

    always #2.5 clk = ~clk;

    nbt_sram_core #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .ce(ce), .gw(gw),
        .bwe(bwe), .byte_en(byte_en), .addr(addr), .dq_in(dq_in),
        .oe(oe), .sleep(sleep), .dq_out(dq_out), .dq_drv(dq_drv)
    );

    function automatic logic [WW-1:0] apply_lanes(logic [WW-1:0] old,
                                                  logic [WW-1:0] nw, logic [3:0] l);
        logic [WW-1:0] r = old;
        for (int i = 0; i < 4; i++) if (l[i]) r[i*9 +: 9] = nw[i*9 +: 9];
        return r;
    endfunction

    task automatic check(string tag, logic [WW-1:0] act, logic [WW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(int op, logic [AW-1:0] a, logic [3:0] st,
                        logic [WW-1:0] d, bit slp, bit oen, string tag);
        int dly;
        logic [3:0] lanes;
        @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            s_kind[i] = s_kind[i+1]; s_data[i] = s_data[i+1]; s_tag[i] = s_tag[i+1];
        end
        s_kind[2] = 0;
        // Slot due in this cycle.
        if (s_kind[0] == 1) begin
            check(s_tag[0], {35'd0, dq_drv}, {35'd0, oe && !sleep});
            if (oe && !sleep) check(s_tag[0], dq_out, s_data[0]);
        end else begin
            check(s_kind[0] == 2 ? "R4" : "R11", {35'd0, dq_drv}, 36'd0);
            dq_in = (s_kind[0] == 2) ? s_data[0] : {$urandom, $urandom}[WW-1:0];
        end
        // New command for the coming edge.
        oe = oen; sleep = slp;
        ce = (op != OP_IDLE);
        gw = (op == OP_GW) || (op == OP_GWBW);
        bwe = (op == OP_BW) || (op == OP_GWBW);
        byte_en = st; addr = a;
        if (s_kind[0] == 1 && (!oen || slp)) begin
            #1;
            check(slp ? "R9" : "R10", {35'd0, dq_drv}, 36'd0);
        end
        dly = pipe_mode ? 2 : 1;
        if (op != OP_IDLE && !slp) begin
            if (op == OP_RD) begin
                s_kind[dly] = 1; s_data[dly] = ref_mem[a]; s_tag[dly] = tag;
            end else begin
                lanes = (op == OP_BW) ? st : 4'hF;
                ref_mem[a] = apply_lanes(ref_mem[a], d, lanes);
                s_kind[dly] = 2; s_data[dly] = d; s_tag[dly] = tag;
            end
        end
    endtask

    task automatic idles(int n);
        for (int i = 0; i < n; i++) step(OP_IDLE, '0, '0, '0, 0, 1, "R11");
    endtask

    function automatic logic [WW-1:0] rnd_word();
        return {$urandom, $urandom}[WW-1:0];
    endfunction

    task automatic random_phase(int n);
        for (int i = 0; i < n; i++) begin
            int r = $urandom % 10;
            int op = (r < 4) ? OP_RD : (r < 6) ? OP_BW : (r < 8) ? OP_GW :
                     (r < 9) ? OP_GWBW : OP_IDLE;
            logic [AW-1:0] a = ($urandom % 4 == 0) ? AW'($urandom) : AW'($urandom % 6);
            step(op, a, 4'($urandom), rnd_word(), ($urandom % 16) == 0,
                 ($urandom % 8) != 0, "R7");
        end
    endtask

    task automatic directed(string md);
        logic [WW-1:0] v;
        // R2 / R3: plain read latency of the current mode
        step(OP_GW, 6'd5, '0, 36'h1_2345_6789, 0, 1, "R6");
        idles(2);
        step(OP_RD, 6'd5, '0, '0, 0, 1, pipe_mode ? "R3" : "R2");
        idles(3);
        // R5: partial lanes, then no lanes
        step(OP_BW, 6'd5, 4'b0101, 36'hF_FFFF_FFFF, 0, 1, "R5");
        step(OP_RD, 6'd5, '0, '0, 0, 1, "R5");
        step(OP_BW, 6'd5, 4'b0000, 36'h0_0000_0000, 0, 1, "R5");
        step(OP_RD, 6'd5, '0, '0, 0, 1, "R5");
        // R6: global write overrides partial strobes
        step(OP_GWBW, 6'd6, 4'b0001, 36'hA_BCDE_F012, 0, 1, "R6");
        step(OP_RD, 6'd6, '0, '0, 0, 1, "R6");
        // R8: read right after a byte write to the same word
        step(OP_BW, 6'd6, 4'b1010, 36'h5_5555_5555, 0, 1, "R8");
        step(OP_RD, 6'd6, '0, '0, 0, 1, "R8");
        // R4: write data slot, then a read well after
        v = rnd_word();
        step(OP_GW, 6'd7, '0, v, 0, 1, "R4");
        idles(3);
        step(OP_RD, 6'd7, '0, '0, 0, 1, "R4");
        // R7: read-write-read-write with no gaps
        step(OP_RD, 6'd7, '0, '0, 0, 1, "R7");
        step(OP_GW, 6'd7, '0, rnd_word(), 0, 1, "R7");
        step(OP_RD, 6'd7, '0, '0, 0, 1, "R7");
        step(OP_GW, 6'd8, '0, rnd_word(), 0, 1, "R7");
        step(OP_RD, 6'd8, '0, '0, 0, 1, "R7");
        // R9: write under sleep is ignored, data kept
        step(OP_GW, 6'd8, '0, 36'h0_DEAD_BEEF, 1, 1, "R9");
        step(OP_RD, 6'd8, '0, '0, 1, 1, "R9");
        idles(3);
        step(OP_RD, 6'd8, '0, '0, 0, 1, "R9");
        // R10: read due, output enable dropped in its cycle
        step(OP_RD, 6'd7, '0, '0, 0, 1, "R10");
        step(OP_IDLE, '0, '0, '0, 0, 1, "R10");
        if (pipe_mode) step(OP_IDLE, '0, '0, '0, 0, 0, "R10");
        else           step(OP_IDLE, '0, '0, '0, 0, 0, "R10");
        // R11: idle slot drives nothing
        step(OP_IDLE, '0, '0, '0, 0, 1, "R11");
        idles(3);
        $display("directed block done (%s)", md);
    endtask

    initial begin
        void'($urandom(32'd1357));
        for (int i = 0; i < 3; i++) begin s_kind[i] = 0; s_data[i] = '0; s_tag[i] = ""; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", {35'd0, dq_drv}, 36'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {35'd0, dq_drv}, 36'd0);
        for (int a = 0; a < DEPTH; a++) step(OP_GW, AW'(a), '0, rnd_word(), 0, 1, "R6");
        idles(3);
        directed("flow-through");
        random_phase(500);
        idles(3);
        pipe_mode = 1'b1;
        directed("pipelined");
        random_phase(500);
        idles(3);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule